// File: doc/BRIEF.md
# Multi-lane stream rule monitor

This block sits beside a multi-lane streaming interface and watches it without driving anything back. The interface moves up to `LANES` elements per transfer under a valid/ready handshake. It also carries a start-lane index, an end-lane index, a strobe bit per lane, and `DIMS` last bits per lane. A complexity level `CPLX` decides which signalling rules the source must follow. On each accepted transfer the monitor evaluates every rule that applies at that level. Each broken rule sets its own bit in a sticky violation vector, and a sticky error flag is raised.

The index fields are taken as meaningful only when every strobe bit is high. The monitor keeps one bit of stream state. That bit records whether the innermost sequence has received data without being closed. With it, a late termination can be told apart from a legal empty sequence. A synchronous clear input empties the violation vector and the error flag. The monitor is meant for simulation benches and for on-chip debug taps.

Top module: `mlstream_rule_checker`

## Requirements
- R1: No violation bit changes on a cycle where `mon_valid` and `mon_ready` are not both high, whatever the other inputs carry.
- R2: Bit 0 of `viol_o` is set when `CPLX` < 8 and any last bit of lanes 0 to `LANES`-2 is high. Last bits are packed lane-major, so lane i uses `mon_last[i*DIMS +: DIMS]`, with dimension j at offset j.
- R3: Bit 1 is set when `CPLX` < 8 and the strobe bits are neither all high nor all low.
- R4: Bit 2 is set when `CPLX` < 6, all strobe bits are high, and `mon_stai` is not 0.
- R5: Bit 3 is set when `CPLX` < 5, all strobe bits are high, no last bit in any lane is high, and `mon_endi` is not `LANES`-1.
- R6: Bit 4 is set when `CPLX` < 4 and, in the top lane, some dimension j ≥ 1 has its last bit high while dimension j-1 has its last bit low.
- R7: Bit 5 is set when `CPLX` < 4 and the top lane's dimension-0 last bit is high on a transfer with no strobe bit high, while the innermost sequence is open. The sequence opens on a transfer with data and no dimension-0 last bit in any lane. It closes on any transfer carrying a dimension-0 last bit. It is closed after reset. The same pattern on a closed sequence is a legal empty sequence.
- R8: Bit 6 is set on any complexity when all strobe bits are high and `mon_stai` > `mon_endi`. When any strobe bit is low, the index fields are ignored by every rule.
- R9: Violation bits and `err_o` stay set until `mon_clr` is high on a clock edge, which zeroes them. A clear wins over a violation accepted in the same cycle. `err_o` equals the OR of the violation bits.
- R10: A violation accepted at a clock edge is visible at the outputs right after that edge. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clr | input | 1 | Synchronous clear of violations and error |
| mon_valid | input | 1 | Observed source valid |
| mon_ready | input | 1 | Observed sink ready |
| mon_stai | input | $clog2(LANES) | Observed start-lane index |
| mon_endi | input | $clog2(LANES) | Observed end-lane index |
| mon_strb | input | LANES | Observed per-lane strobe |
| mon_last | input | LANES*DIMS | Observed per-lane last bits, lane-major |
| viol_o | output | 7 | Sticky per-rule violation bits |
| err_o | output | 1 | Sticky error flag |

## Verification
The assertions assume that the watched handshake is sampled synchronously to `clk` and that the inputs hold no X or Z values on an accepted cycle. They also assume that `LANES` is at least 2 and `DIMS` at least 1. The stimulus changes inputs only on falling edges and keeps `mon_clr` low on every accepted test transfer. Before each test transfer, the bench puts the open-sequence state into a known value with a legal closing transfer, optionally followed by a legal data transfer. The exhaustive sweep therefore starts every case from a state the bench knows.

// File: rtl/mlstream_chk_pkg.sv
package mlstream_chk_pkg;
  localparam int RULE_CNT    = 7;
  localparam int RB_LOWLAST  = 0;
  localparam int RB_STRBMIX  = 1;
  localparam int RB_STAI     = 2;
  localparam int RB_ENDI     = 3;
  localparam int RB_NEST     = 4;
  localparam int RB_POSTPONE = 5;
  localparam int RB_ORDER    = 6;
  typedef logic [RULE_CNT-1:0] rule_vec_t;
endpackage

// File: rtl/mlstream_rule_eval.sv
module mlstream_rule_eval
  import mlstream_chk_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DIMS  = 2,
  parameter int CPLX  = 3,
  localparam int IW   = $clog2(LANES),
  localparam int LW   = LANES * DIMS
) (
  input  logic [IW-1:0]    stai,
  input  logic [IW-1:0]    endi,
  input  logic [LANES-1:0] strb,
  input  logic [LW-1:0]    last,
  input  logic             seq_open,
  output rule_vec_t        hits
);
  localparam int TOPB = (LANES - 1) * DIMS;

  logic [DIMS-1:0] top_last;
  logic [TOPB-1:0] low_last;
  logic            all_on, any_on, nest_bad;

  assign top_last = last[TOPB +: DIMS];
  assign low_last = last[TOPB-1:0];
  assign all_on   = &strb;
  assign any_on   = |strb;

  always_comb begin
    nest_bad = 1'b0;
    for (int j = 1; j < DIMS; j++) begin
      if (top_last[j] && !top_last[j-1]) nest_bad = 1'b1;
    end
  end

  always_comb begin
    hits              = '0;
    hits[RB_LOWLAST]  = (CPLX < 8) && (|low_last);
    hits[RB_STRBMIX]  = (CPLX < 8) && any_on && !all_on;
    hits[RB_STAI]     = (CPLX < 6) && all_on && (stai != '0);
    hits[RB_ENDI]     = (CPLX < 5) && all_on && !(|last) && (endi != IW'(LANES - 1));
    hits[RB_NEST]     = (CPLX < 4) && nest_bad;
    hits[RB_POSTPONE] = (CPLX < 4) && top_last[0] && !any_on && seq_open;
    hits[RB_ORDER]    = all_on && (stai > endi);
  end
endmodule

// File: rtl/mlstream_seq_tracker.sv
module mlstream_seq_tracker #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [LANES-1:0] strb,
  input  logic [LANES-1:0] dim0_last,
  output logic             seq_open
);
  logic open_q, open_d;

  always_comb begin
    open_d = open_q;
    if (fire) begin
      if (|dim0_last)  open_d = 1'b0;
      else if (|strb)  open_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  assign seq_open = open_q;

  p_close_on_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && |dim0_last) |=> !seq_open);
  p_open_on_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(|dim0_last) && |strb) |=> seq_open);
endmodule

// File: rtl/mlstream_viol_bank.sv
module mlstream_viol_bank
  import mlstream_chk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      fire,
  input  rule_vec_t hits,
  output rule_vec_t viol,
  output logic      err
);
  rule_vec_t viol_q, viol_d;
  logic      err_q, err_d;

  always_comb begin
    viol_d = viol_q;
    err_d  = err_q;
    if (clr) begin
      viol_d = '0;
      err_d  = 1'b0;
    end else if (fire) begin
      viol_d = viol_q | hits;
      err_d  = err_q | (|hits);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= '0;
      err_q  <= 1'b0;
    end else begin
      viol_q <= viol_d;
      err_q  <= err_d;
    end
  end

  assign viol = viol_q;
  assign err  = err_q;

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !clr) |=> $stable(viol));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (viol == '0 && !err));
  p_err_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err == (|viol));
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((viol & $past(viol)) == $past(viol)));
endmodule

// File: rtl/mlstream_rule_checker.sv
module mlstream_rule_checker
  import mlstream_chk_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DIMS  = 2,
  parameter int CPLX  = 3,
  localparam int IW   = $clog2(LANES),
  localparam int LW   = LANES * DIMS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mon_clr,
  input  logic                mon_valid,
  input  logic                mon_ready,
  input  logic [IW-1:0]       mon_stai,
  input  logic [IW-1:0]       mon_endi,
  input  logic [LANES-1:0]    mon_strb,
  input  logic [LW-1:0]       mon_last,
  output logic [RULE_CNT-1:0] viol_o,
  output logic                err_o
);
  logic             fire, seq_open;
  logic [LANES-1:0] dim0_last;
  rule_vec_t        hits;

  assign fire = mon_valid && mon_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_dim0
    assign dim0_last[i] = mon_last[i*DIMS];
  end

  mlstream_seq_tracker #(.LANES(LANES)) trk_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .strb(mon_strb),
    .dim0_last(dim0_last), .seq_open(seq_open)
  );

  mlstream_rule_eval #(.LANES(LANES), .DIMS(DIMS), .CPLX(CPLX)) eval_i (
    .stai(mon_stai), .endi(mon_endi), .strb(mon_strb), .last(mon_last),
    .seq_open(seq_open), .hits(hits)
  );

  mlstream_viol_bank bank_i (
    .clk(clk), .rst_n(rst_n), .clr(mon_clr), .fire(fire),
    .hits(hits), .viol(viol_o), .err(err_o)
  );

  if (CPLX < 8) begin : g_lowlast_chk
    p_lane_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !mon_clr && |mon_last[(LANES-1)*DIMS-1:0]) |=> viol_o[RB_LOWLAST]);
  end
  if (CPLX < 6) begin : g_stai_chk
    p_stai_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !mon_clr && &mon_strb && mon_stai != '0) |=> viol_o[RB_STAI]);
  end
  p_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mon_clr && &mon_strb && mon_stai > mon_endi) |=> viol_o[RB_ORDER]);
endmodule

// File: tb/mlstream_rule_checker_tb_top.sv
module mlstream_rule_checker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int D = 2;

  logic clk = 1'b0;
  logic rst_n, clr, valid, ready;
  logic [1:0] stai, endi;
  logic [3:0] strb;
  logic [7:0] lastv;
  logic [6:0] viol_a, viol_b;
  logic err_a, err_b;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mlstream_rule_checker #(.LANES(N), .DIMS(D), .CPLX(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .mon_clr(clr), .mon_valid(valid), .mon_ready(ready),
    .mon_stai(stai), .mon_endi(endi), .mon_strb(strb), .mon_last(lastv),
    .viol_o(viol_a), .err_o(err_a));

  mlstream_rule_checker #(.LANES(N), .DIMS(D), .CPLX(7)) dut_hi_i (
    .clk(clk), .rst_n(rst_n), .mon_clr(clr), .mon_valid(valid), .mon_ready(ready),
    .mon_stai(stai), .mon_endi(endi), .mon_strb(strb), .mon_last(lastv),
    .viol_o(viol_b), .err_o(err_b));

  function automatic logic [6:0] model(int c, logic [1:0] s, logic [1:0] e,
                                       logic [3:0] st, logic [7:0] l, bit open);
    logic [6:0] r = '0;
    bit all_on = (st == 4'hF);
    bit any_on = (st != 4'h0);
    logic [1:0] top = l[7:6];
    r[0] = (c < 8) && (l[5:0] != 0);
    r[1] = (c < 8) && any_on && !all_on;
    r[2] = (c < 6) && all_on && (s != 0);
    r[3] = (c < 5) && all_on && (l == 0) && (e != 2'd3);
    r[4] = (c < 4) && top[1] && !top[0];
    r[5] = (c < 4) && top[0] && !any_on && open;
    r[6] = all_on && (s > e);
    return r;
  endfunction

  task automatic cmp(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic xfer(bit v, logic [1:0] s, logic [1:0] e, logic [3:0] st, logic [7:0] l);
    valid = v; stai = s; endi = e; strb = st; lastv = l;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; valid = 1'b0; ready = 1'b1;
    stai = '0; endi = '0; strb = '0; lastv = '0;
    repeat (3) @(negedge clk);
    // R10: outputs clear after reset
    cmp("R10 reset", {err_a, viol_a}, 8'h00);
    cmp("R10 reset", {err_b, viol_b}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: illegal content while not accepted
    ready = 1'b0;
    xfer(1'b1, 2'd3, 2'd0, 4'b0101, 8'hFF);
    ready = 1'b1;
    xfer(1'b0, 2'd3, 2'd0, 4'b0101, 8'hFF);
    cmp("R1 idle", {err_a, viol_a}, 8'h00);
    cmp("R1 idle", {err_b, viol_b}, 8'h00);

    // R9: clear wins over same-cycle violation
    clr = 1'b1;
    xfer(1'b1, 2'd3, 2'd0, 4'b0101, 8'hFF);
    clr = 1'b0;
    cmp("R9 clear priority", {err_a, viol_a}, 8'h00);

    // R9: stickiness across a later legal transfer
    xfer(1'b1, 2'd2, 2'd3, 4'hF, 8'h40);
    xfer(1'b1, 2'd0, 2'd3, 4'hF, 8'h00);
    cmp("R9 sticky", {err_a, viol_a}, {1'b1, 7'b0000100});
    do_clear();
    cmp("R9 cleared", {err_a, viol_a}, 8'h00);

    // R7: empty sequence right after a close is legal, then postponed last is not
    xfer(1'b1, 2'd0, 2'd3, 4'hF, 8'h40);
    do_clear();
    xfer(1'b1, 2'd0, 2'd3, 4'h0, 8'h40);
    cmp("R7 empty sequence", {err_a, viol_a}, 8'h00);
    xfer(1'b1, 2'd0, 2'd3, 4'hF, 8'h00);
    xfer(1'b1, 2'd0, 2'd3, 4'h0, 8'h40);
    cmp("R7 postponed last", {err_a, viol_a}, {1'b1, 7'b0100000});
    do_clear();

    // R2..R8 exhaustive sweep over both complexity levels
    for (int pre = 0; pre < 2; pre++)
      for (int s = 0; s < 4; s++)
        for (int e = 0; e < 4; e++)
          for (int st = 0; st < 16; st++)
            for (int tp = 0; tp < 4; tp++)
              for (int lo = 0; lo < 2; lo++) begin
                logic [7:0] l;
                logic [6:0] ea, eb;
                l = {2'(tp), 5'b0, 1'(lo)};
                xfer(1'b1, 2'd0, 2'd3, 4'hF, 8'h40);
                if (pre == 1) xfer(1'b1, 2'd0, 2'd3, 4'hF, 8'h00);
                do_clear();
                xfer(1'b1, 2'(s), 2'(e), 4'(st), l);
                ea = model(3, 2'(s), 2'(e), 4'(st), l, pre == 1);
                eb = model(7, 2'(s), 2'(e), 4'(st), l, pre == 1);
                cmp("R2-R8 sweep C3 (R2 R3 R4 R5 R6 R7 R8)", {err_a, viol_a}, {|ea, ea});
                cmp("R2-R8 sweep C7 (R2 R3 R8)", {err_b, viol_b}, {|eb, eb});
              end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule